// File: doc/BRIEF.md
# Host Mailbox Transaction Sequencer

This block sits on the host side of a byte-wide register window into a remote mailbox. A single start pulse makes it run one whole mailbox exchange. It marks the mailbox as pending, loads the command byte and a 32-bit argument, and rings the doorbell. It then polls the remote status register until the completion bit shows, pausing between polls. For read commands it fetches four response bytes. Last, it writes the completion bit back to acknowledge it.

The user side is a start/busy/done handshake carrying a command byte, an argument word and a read flag. The block returns a 32-bit response word and an error flag. The register side is a request/acknowledge port with one access in flight at a time. Either side can end an access with an error, which stops the exchange at once. The pause between polls is a cycle count set by a parameter. Choose it so that the pause lands in the 50 to 100 microsecond range at the clock in use.

Top module: `host_mailbox_seq`

## Requirements
- R1: A start pulse seen while idle begins a transaction. busy is high from the next cycle until the cycle in which done is high, when busy is low. A start seen while busy is ignored, and so are any cmd, din or rd changes during a transaction.
- R2: The transaction opens with seven writes in this order: address 0x3F gets 0x80, then 0x38 gets the command byte, then 0x39, 0x3A, 0x3B and 0x3C get din[7:0], din[15:8], din[23:16] and din[31:24], then 0x40 gets 0x01.
- R3: An access holds bus_req high with bus_addr, bus_we and bus_wdata unchanged until the cycle in which bus_ack or bus_err is sampled. bus_req is low in the following cycle.
- R4: After the doorbell the block reads status address 0x02. If bit 1 of the returned byte is 1, polling ends. Otherwise the next status read follows after at least WAIT_CYCLES cycles with bus_req low.
- R5: At most MAX_POLLS (default 11) status reads are made. If none of them returns bit 1 set, the transaction ends with done and err high, and no further access is made.
- R6: When rd is 1, polling is followed by reads of 0x31, 0x32, 0x33 and 0x34, whose bytes form dout[7:0], [15:8], [23:16] and [31:24]. When rd is 0 these reads are skipped and dout stays zero.
- R7: The final access writes, to address 0x02, the last status byte read with bit 1 forced to 1. The transaction then ends with done high and err low.
- R8: bus_err sampled on any access ends the transaction in the next cycle with done and err high, and no further access is made.
- R9: dout is zero from the cycle after an accepted start. done is high for exactly one cycle. err is valid in that cycle and stays unchanged until the next accepted start.
- R10: During and right after reset, busy, done, err and bus_req are low and dout is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transaction (taken only while idle) |
| cmd | input | 8 | Command byte |
| din | input | 32 | Command argument word |
| rd | input | 1 | 1: read command, fetch response word |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Transaction ended by timeout or bus error |
| dout | output | 32 | Response word of a read command |
| bus_req | output | 1 | Register access request |
| bus_addr | output | 8 | Register address |
| bus_we | output | 1 | 1: write access, 0: read access |
| bus_wdata | output | 8 | Write byte |
| bus_rdata | input | 8 | Read byte, valid with bus_ack |
| bus_ack | input | 1 | Access completed |
| bus_err | input | 1 | Access failed |

## Verification
The assertions assume that the register side raises bus_ack or bus_err only while bus_req is high, for a single cycle per access, and never both at once. The bench responder keeps to that. It answers each request once after a chosen latency of zero to three cycles, drops its answer in the next cycle, and injects bus_err in place of bus_ack on a chosen access. The start pulses from the bench last one cycle. The one start given in the middle of a transaction also changes cmd, din and rd, and nothing in the access sequence may follow that change.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int BSEL_W     = $clog2(WORD_BYTES);

  // step numbering: the order of accesses within one transaction
  localparam int I_PEND  = 0;
  localparam int I_CMD   = 1;
  localparam int I_DIN0  = 2;
  localparam int I_KICK  = I_DIN0 + WORD_BYTES;
  localparam int I_POLL  = I_KICK + 1;
  localparam int I_RESP0 = I_POLL + 1;
  localparam int I_CLEAR = I_RESP0 + WORD_BYTES;
  localparam int STEP_W  = $clog2(I_CLEAR + 1);

  typedef logic [STEP_W-1:0] step_t;

  localparam step_t STEP_PEND  = step_t'(I_PEND);
  localparam step_t STEP_CMD   = step_t'(I_CMD);
  localparam step_t STEP_DIN0  = step_t'(I_DIN0);
  localparam step_t STEP_KICK  = step_t'(I_KICK);
  localparam step_t STEP_POLL  = step_t'(I_POLL);
  localparam step_t STEP_RESP0 = step_t'(I_RESP0);
  localparam step_t STEP_CLEAR = step_t'(I_CLEAR);

  localparam logic [7:0] ADDR_PEND  = 8'h3F;
  localparam logic [7:0] ADDR_CMD   = 8'h38;
  localparam logic [7:0] ADDR_DIN0  = 8'h39;
  localparam logic [7:0] ADDR_KICK  = 8'h40;
  localparam logic [7:0] ADDR_STAT  = 8'h02;
  localparam logic [7:0] ADDR_RESP0 = 8'h31;

  localparam logic [7:0] VAL_PEND   = 8'h80;
  localparam logic [7:0] VAL_KICK   = 8'h01;
  localparam int         ALERT_BIT  = 1;
  localparam logic [7:0] ALERT_MASK = 8'h02;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LOAD,
    S_BUS,
    S_WAIT
  } seq_state_t;
endpackage

// File: rtl/mbx_step_decode.sv
module mbx_step_decode
  import mbx_pkg::*;
(
  input  step_t             step,
  input  logic [7:0]        cmd,
  input  logic [WORD_W-1:0] din,
  input  logic [7:0]        status,
  output logic [7:0]        addr,
  output logic              we,
  output logic [7:0]        wdata
);
  logic [7:0]        din_bytes [WORD_BYTES];
  logic [BSEL_W-1:0] din_sel;
  logic [BSEL_W-1:0] resp_sel;

  generate
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_split
      assign din_bytes[g] = din[8*g +: 8];
    end
  endgenerate

  assign din_sel  = BSEL_W'(step - STEP_DIN0);
  assign resp_sel = BSEL_W'(step - STEP_RESP0);

  always_comb begin
    addr  = ADDR_STAT;
    we    = 1'b0;
    wdata = '0;
    if (step == STEP_PEND) begin
      addr  = ADDR_PEND;
      we    = 1'b1;
      wdata = VAL_PEND;
    end else if (step == STEP_CMD) begin
      addr  = ADDR_CMD;
      we    = 1'b1;
      wdata = cmd;
    end else if (step >= STEP_DIN0 && step < STEP_KICK) begin
      addr  = ADDR_DIN0 + 8'(din_sel);
      we    = 1'b1;
      wdata = din_bytes[din_sel];
    end else if (step == STEP_KICK) begin
      addr  = ADDR_KICK;
      we    = 1'b1;
      wdata = VAL_KICK;
    end else if (step >= STEP_RESP0 && step < STEP_CLEAR) begin
      addr  = ADDR_RESP0 + 8'(resp_sel);
    end else if (step == STEP_CLEAR) begin
      addr  = ADDR_STAT;
      we    = 1'b1;
      wdata = status | ALERT_MASK;
    end
  end
endmodule

// File: rtl/mbx_wait_timer.sv
module mbx_wait_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(CYCLES - 1);
    end else if (run && cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign expired = run && (cnt == '0);
endmodule

// File: rtl/host_mailbox_seq.sv
module host_mailbox_seq
  import mbx_pkg::*;
#(
  parameter int WAIT_CYCLES = 5000,
  parameter int MAX_POLLS   = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [7:0]  cmd,
  input  logic [31:0] din,
  input  logic        rd,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [31:0] dout,
  output logic        bus_req,
  output logic [7:0]  bus_addr,
  output logic        bus_we,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata,
  input  logic        bus_ack,
  input  logic        bus_err
);
  localparam int PCW = $clog2(MAX_POLLS + 1);

  seq_state_t        state;
  step_t             step;
  logic [PCW-1:0]    poll_cnt;
  logic [7:0]        cmd_q;
  logic [WORD_W-1:0] din_q;
  logic              rd_q;
  logic [7:0]        status_q;
  logic [7:0]        dec_addr;
  logic              dec_we;
  logic [7:0]        dec_wdata;
  logic              tmr_expired;
  logic              acc_ok;
  logic              poll_hit;
  logic              last_poll;
  logic              go_wait;
  logic [BSEL_W-1:0] resp_sel;

  mbx_step_decode u_dec (
    .step   (step),
    .cmd    (cmd_q),
    .din    (din_q),
    .status (status_q),
    .addr   (dec_addr),
    .we     (dec_we),
    .wdata  (dec_wdata)
  );

  assign acc_ok    = (state == S_BUS) && bus_ack && !bus_err;
  assign poll_hit  = bus_rdata[ALERT_BIT];
  assign last_poll = (poll_cnt == PCW'(MAX_POLLS - 1));
  assign go_wait   = acc_ok && (step == STEP_POLL) && !poll_hit && !last_poll;
  assign resp_sel  = BSEL_W'(step - STEP_RESP0);

  mbx_wait_timer #(.CYCLES(WAIT_CYCLES)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (go_wait),
    .run     (state == S_WAIT),
    .expired (tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      step      <= STEP_PEND;
      poll_cnt  <= '0;
      cmd_q     <= '0;
      din_q     <= '0;
      rd_q      <= 1'b0;
      status_q  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      dout      <= '0;
      bus_req   <= 1'b0;
      bus_addr  <= '0;
      bus_we    <= 1'b0;
      bus_wdata <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            cmd_q    <= cmd;
            din_q    <= din;
            rd_q     <= rd;
            dout     <= '0;
            err      <= 1'b0;
            busy     <= 1'b1;
            step     <= STEP_PEND;
            poll_cnt <= '0;
            state    <= S_LOAD;
          end
        end
        S_LOAD: begin
          bus_req   <= 1'b1;
          bus_addr  <= dec_addr;
          bus_we    <= dec_we;
          bus_wdata <= dec_wdata;
          state     <= S_BUS;
        end
        S_BUS: begin
          if (bus_err) begin
            bus_req <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b1;
            err     <= 1'b1;
            state   <= S_IDLE;
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            state   <= S_LOAD;
            if (step < STEP_POLL) begin
              step <= step + step_t'(1);
            end else if (step == STEP_POLL) begin
              status_q <= bus_rdata;
              poll_cnt <= poll_cnt + PCW'(1);
              if (poll_hit) begin
                step <= rd_q ? STEP_RESP0 : STEP_CLEAR;
              end else if (last_poll) begin
                busy  <= 1'b0;
                done  <= 1'b1;
                err   <= 1'b1;
                state <= S_IDLE;
              end else begin
                state <= S_WAIT;
              end
            end else if (step < STEP_CLEAR) begin
              dout[8*resp_sel +: 8] <= bus_rdata;
              step <= step + step_t'(1);
            end else begin
              busy  <= 1'b0;
              done  <= 1'b1;
              state <= S_IDLE;
            end
          end
        end
        S_WAIT: begin
          if (tmr_expired) state <= S_LOAD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbx_seq_checker.sv
module mbx_seq_checker #(
  parameter int MAX_POLLS = 11
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [31:0] dout,
  input logic        bus_req,
  input logic [7:0]  bus_addr,
  input logic        bus_we,
  input logic [7:0]  bus_wdata,
  input logic        bus_ack,
  input logic        bus_err
);
  logic [7:0] polls_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      polls_seen <= '0;
    end else if (start && !busy) begin
      polls_seen <= '0;
    end else if (bus_req && bus_ack && !bus_err && !bus_we && bus_addr == 8'h02) begin
      polls_seen <= polls_seen + 8'd1;
    end
  end

  p_hold_req_r3: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack && !bus_err |=>
      bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  p_drop_req_r3: assert property (@(posedge clk) disable iff (rst)
    bus_req && (bus_ack || bus_err) |=> !bus_req);

  p_req_in_txn_r1: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> busy);

  p_done_ends_busy_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));

  p_pend_value_r2: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we && bus_addr == 8'h3F |-> bus_wdata == 8'h80);

  p_kick_value_r2: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we && bus_addr == 8'h40 |-> bus_wdata == 8'h01);

  p_poll_bound_r5: assert property (@(posedge clk) disable iff (rst)
    polls_seen <= 8'(MAX_POLLS));

  p_clear_bit_r7: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we && bus_addr == 8'h02 |-> bus_wdata[1]);

  p_abort_r8: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_err |=> done && err && !bus_req);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_dout_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> dout == '0);

  p_err_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done && !busy && !$rose(busy) |-> $stable(err));
endmodule

bind host_mailbox_seq mbx_seq_checker #(.MAX_POLLS(MAX_POLLS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .dout      (dout),
  .bus_req   (bus_req),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_ack   (bus_ack),
  .bus_err   (bus_err)
);

// File: tb/host_mailbox_seq_tb_top.sv
module host_mailbox_seq_tb_top;
  localparam int TB_WAIT  = 6;
  localparam int TB_POLLS = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  cmd = '0;
  logic [31:0] din = '0;
  logic        rd = 1'b0;
  logic        busy, done, err;
  logic [31:0] dout;
  logic        bus_req, bus_we;
  logic [7:0]  bus_addr, bus_wdata;
  logic [7:0]  bus_rdata = '0;
  logic        bus_ack = 1'b0;
  logic        bus_err = 1'b0;

  always #5 clk = ~clk;

  host_mailbox_seq #(.WAIT_CYCLES(TB_WAIT), .MAX_POLLS(TB_POLLS)) dut_i (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .din(din), .rd(rd),
    .busy(busy), .done(done), .err(err), .dout(dout),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err)
  );

  typedef struct packed {
    logic [7:0] addr;
    logic       we;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       fail;
    logic [3:0] tag;
  } acc_t;

  acc_t        expq[$];
  int          n_checks = 0;
  int          n_fail = 0;
  int          cycles = 0;
  bit          m_busy = 0, m_done = 0, m_err = 0, m_end_err = 0;
  logic [31:0] m_dout = '0;
  bit          served = 0;
  int          lat_cnt = 0;
  int          gap = 0;
  bit          prev_poll = 0;

  // transaction descriptor
  logic [7:0]  t_cmd;
  logic [31:0] t_din;
  bit          t_rd;
  int          t_fails;
  logic [7:0]  t_noise;
  logic [7:0]  t_stat;
  logic [31:0] t_resp;
  int          t_errat;
  int          t_lat;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] a, input logic w, input logic [7:0] wd,
                      input logic [7:0] rdv, input logic [3:0] tg);
    acc_t e;
    e.addr = a; e.we = w; e.wdata = wd; e.rdata = rdv; e.fail = 1'b0; e.tag = tg;
    expq.push_back(e);
  endtask

  task automatic build_queue();
    int np;
    expq.delete();
    push(8'h3F, 1'b1, 8'h80, 8'h00, 4'd2);
    push(8'h38, 1'b1, t_cmd, 8'h00, 4'd2);
    for (int b = 0; b < 4; b++) push(8'h39 + 8'(b), 1'b1, t_din[8*b +: 8], 8'h00, 4'd2);
    push(8'h40, 1'b1, 8'h01, 8'h00, 4'd2);
    np = (t_fails >= TB_POLLS) ? TB_POLLS : t_fails + 1;
    for (int i = 0; i < np; i++)
      push(8'h02, 1'b0, 8'h00, (i < t_fails) ? (t_noise & 8'hFD) : t_stat, 4'd4);
    m_end_err = (t_fails >= TB_POLLS);
    if (!m_end_err) begin
      if (t_rd) for (int b = 0; b < 4; b++) push(8'h31 + 8'(b), 1'b0, 8'h00, t_resp[8*b +: 8], 4'd6);
      push(8'h02, 1'b1, t_stat | 8'h02, 8'h00, 4'd7);
    end
    if (t_errat >= 0 && t_errat < expq.size()) begin
      while (expq.size() > t_errat + 1) void'(expq.pop_back());
      expq[t_errat].fail = 1'b1;
      m_end_err = 1;
    end
  endtask

  // cycle-by-cycle reference model and bus responder
  always @(negedge clk) begin
    acc_t a;
    if (!rst) begin
      cycles++;
      chk(busy === m_busy, "R1", "busy", 32'(busy), 32'(m_busy));
      chk(done === m_done, "R9", "done", 32'(done), 32'(m_done));
      if (m_done) chk(err === m_err, "R9", "err with done", 32'(err), 32'(m_err));
      chk(dout === m_dout, "R6", "dout", dout, m_dout);
      if (bus_req && !m_busy) chk(1'b0, "R1", "request while idle", 32'(bus_addr), 32'h0);
      m_done  = 0;
      bus_ack = 1'b0;
      bus_err = 1'b0;
      if (start && !m_busy) begin
        build_queue();
        m_busy = 1; m_dout = '0; m_err = 0;
      end
      if (!bus_req) begin
        served = 0; lat_cnt = 0; gap++;
      end else if (!served) begin
        if (lat_cnt == 0 && prev_poll && bus_addr == 8'h02 && !bus_we)
          chk(gap >= TB_WAIT, "R4", "idle cycles between polls", 32'(gap), 32'(TB_WAIT));
        if (lat_cnt < t_lat) begin
          lat_cnt++;
        end else begin
          served = 1;
          gap = 0;
          if (expq.size() == 0) begin
            chk(1'b0, "R5", "access beyond end", 32'(bus_addr), 32'h0);
            bus_ack = 1'b1;
          end else begin
            a = expq.pop_front();
            chk(bus_addr === a.addr, $sformatf("R%0d", a.tag), "addr", 32'(bus_addr), 32'(a.addr));
            chk(bus_we === a.we, $sformatf("R%0d", a.tag), "we", 32'(bus_we), 32'(a.we));
            if (a.we) chk(bus_wdata === a.wdata, $sformatf("R%0d", a.tag), "wdata",
                          32'(bus_wdata), 32'(a.wdata));
            if (a.fail) bus_err = 1'b1;
            else begin bus_ack = 1'b1; bus_rdata = a.rdata; end
            if (!a.fail && !a.we && a.addr >= 8'h31 && a.addr <= 8'h34)
              m_dout[8*(a.addr - 8'h31) +: 8] = a.rdata;
            prev_poll = (a.addr == 8'h02) && !a.we;
            if (a.fail || expq.size() == 0) begin
              m_busy = 0; m_done = 1; m_err = m_end_err;
            end
          end
        end
      end
      if (cycles > 150000) begin
        n_fail++;
        $display("FAIL R1 watchdog: actual %0d expected below 150000", cycles);
        $display("  %0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
      end
    end
  end

  task automatic run_txn(input logic [7:0] c, input logic [31:0] d, input bit r,
                         input int fails, input logic [7:0] noise, input logic [7:0] stat,
                         input logic [31:0] resp, input int errat, input int lat,
                         input bit poke, input string req);
    bit exp_err;
    int wait_n;
    t_cmd = c; t_din = d; t_rd = r; t_fails = fails; t_noise = noise; t_stat = stat;
    t_resp = resp; t_errat = errat; t_lat = lat;
    @(posedge clk); #2;
    cmd = c; din = d; rd = r; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    if (poke) begin
      repeat (5) @(posedge clk);
      #2;
      start = 1'b1; cmd = 8'hEE; din = ~d; rd = ~r;   // R1: ignored while busy
      @(posedge clk); #2;
      start = 1'b0;
    end
    wait_n = 0;
    do begin
      @(negedge clk);
      wait_n++;
    end while (!done && wait_n < 5000);
    exp_err = (fails >= TB_POLLS) || (errat >= 0);
    chk(done === 1'b1, req, "transaction finished", 32'(done), 32'h1);
    chk(err === exp_err, req, "final err", 32'(err), 32'(exp_err));
    if (!exp_err) chk(dout === (r ? resp : 32'h0), req, "final dout", dout, r ? resp : 32'h0);
    chk(expq.size() == 0, req, "accesses left", 32'(expq.size()), 32'h0);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(busy === 1'b0, "R10", "busy", 32'(busy), 32'h0);
    chk(done === 1'b0, "R10", "done", 32'(done), 32'h0);
    chk(err === 1'b0, "R10", "err", 32'(err), 32'h0);
    chk(bus_req === 1'b0, "R10", "bus_req", 32'(bus_req), 32'h0);
    chk(dout === 32'h0, "R10", "dout", dout, 32'h0);
    // R2 R7: write command, done on first poll
    run_txn(8'h02, 32'h12345678, 0, 0, 8'h00, 8'h02, 32'h0, -1, 0, 0, "R7");
    // R4 R6: read command, two busy polls with noise bits
    run_txn(8'h01, 32'h00000000, 1, 2, 8'hFD, 8'h43, 32'hA1B2C3D4, -1, 2, 0, "R6");
    // R5: timeout after eleven polls, no clear write
    run_txn(8'h02, 32'hCAFEF00D, 0, 11, 8'h81, 8'h02, 32'h0, -1, 1, 0, "R5");
    // R8: bus error on second argument byte
    run_txn(8'h03, 32'h01020304, 1, 0, 8'h00, 8'h02, 32'h55667788, 3, 0, 0, "R8");
    // R1: start during transaction is ignored
    run_txn(8'h03, 32'h89ABCDEF, 1, 1, 8'h00, 8'h0A, 32'h0BADF00D, -1, 1, 1, "R1");
    // R4 R5: completion on the last allowed poll
    run_txn(8'h01, 32'h0000FFFF, 1, 10, 8'h10, 8'h06, 32'hFFFF0001, -1, 0, 0, "R5");
    // R9: write after read returns zero word
    run_txn(8'h02, 32'h00000064, 0, 0, 8'h00, 8'hF2, 32'h0, -1, 3, 0, "R9");
    // R8: error during response readback
    run_txn(8'h01, 32'h0, 1, 0, 8'h00, 8'h02, 32'h11223344, 9, 1, 0, "R8");
    // R8: error on a status poll
    run_txn(8'h04, 32'h0, 0, 1, 8'h00, 8'h02, 32'h0, 8, 0, 0, "R8");
    // R7: error on the clear write
    run_txn(8'h02, 32'h7, 0, 0, 8'h00, 8'h02, 32'h0, 8, 2, 0, "R7");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule